// File: doc/BRIEF.md
# Streaming Trapezoidal Sample Integrator

This block keeps a running integral over a stream of signed function samples. Every accepted sample counts as one unit step along the x axis, and any step size or gain is left to logic downstream. A window opens on a clear strobe. The mode latched at that moment selects one of two rules for the rest of the window.

In rectangle mode every sample is added as it stands. In trapezoid mode each new sample adds the mean of itself and the sample before it. That mean equals the smaller of the two samples plus half of their absolute difference. For this reason the first sample of a window only loads the previous-sample register.

The integral is a signed fixed-point word with one fractional bit. Bit 0 weighs one half. The integer part has enough headroom for a full window of worst-case samples. If the sum still goes past the range, it saturates and a sticky overflow flag is raised.

Top module: `trap_integrator`

## Requirements
- R1: After reset, `integral` is 0 and `out_valid` and `overflow` are 0. The mode is rectangle until the first clear.
- R2: In rectangle mode, each accepted sample s adds s to the integral. In the output's half-unit encoding, the output word grows by 2*s.
- R3: In trapezoid mode, each accepted sample after the first of a window adds the mean (p+s)/2 of the previous sample p and the current sample s. The output word grows by p+s, so the half bit is kept exactly.
- R4: In trapezoid mode, the first accepted sample of a window adds nothing. This holds whether the window was opened by reset or by a clear. The sample only becomes the previous sample.
- R5: A clear zeroes the integral, forgets the previous sample and drops the overflow flag. A sample accepted in the same cycle as the clear is the first sample of the new window.
- R6: `mode_sel` (0 = rectangle, 1 = trapezoid) is taken only in a cycle with `clear` high. Changes at any other time have no effect on the window in progress.
- R7: The integral and `out_valid` are updated on the clock edge that accepts a sample. `out_valid` is high for exactly the one cycle after each accepted sample. With no sample and no clear, the integral holds.
- R8: The integral is SAMPLE_W + clog2(MAX_WINDOW) + 2 bits wide (28 by default). A result beyond the signed range is clamped to the largest or smallest value. `overflow` then stays 1 until a clear or reset.
- R9: For samples f(0)..f(N), take the trapezoid integral over f(0)..f(N) and the rectangle integral over f(1)..f(N). The rectangle result minus the trapezoid result equals (f(N) - f(0))/2. In output words, the difference is f(N) - f(0).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| clear | input | 1 | Opens a new window and latches `mode_sel` |
| in_valid | input | 1 | A sample is present on `in_sample` |
| in_sample | input | SAMPLE_W | Signed function sample |
| mode_sel | input | 1 | Rule for the next window: 0 rectangle, 1 trapezoid |
| integral | output | ACC_W | Signed running integral, bit 0 weighs one half |
| out_valid | output | 1 | High for one cycle after each accepted sample |
| overflow | output | 1 | Sticky saturation flag |

## Verification
The clear strobe and an accepted sample can fall in the same cycle. The bench provokes this by driving both together in both modes. A clear with a sample must give 2*s in rectangle mode and 0 in trapezoid mode, and must drop a set overflow flag. A second pairing is a mode change on a cycle without a clear. The scoreboard judges it by showing that later increments still follow the latched rule.

// File: rtl/trap_integ_pkg.sv
package trap_integ_pkg;

    typedef enum logic {
        MODE_RECT = 1'b0,
        MODE_TRAP = 1'b1
    } integ_mode_e;

endpackage

// File: rtl/tin_window_ctl.sv
module tin_window_ctl
    import trap_integ_pkg::*;
#(
    parameter int SAMPLE_W = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                clear,
    input  logic                in_valid,
    input  logic [SAMPLE_W-1:0] sample,
    input  integ_mode_e         mode_in,
    output integ_mode_e         eff_mode,
    output logic                eff_first,
    output logic [SAMPLE_W-1:0] prev_sample,
    output integ_mode_e         mode_q,
    output logic                prev_valid_q
);

    typedef struct packed {
        integ_mode_e         mode;
        logic [SAMPLE_W-1:0] prev;
        logic                prev_valid;
    } wctl_t;

    wctl_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clear) begin
            st_d.mode       = mode_in;
            st_d.prev_valid = 1'b0;
        end
        if (in_valid) begin
            st_d.prev       = sample;
            st_d.prev_valid = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '{mode: MODE_RECT, prev: '0, prev_valid: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    // the rule and first-sample status that apply to the sample of this cycle
    assign eff_mode     = clear ? mode_in : st_q.mode;
    assign eff_first    = clear | ~st_q.prev_valid;
    assign prev_sample  = st_q.prev;
    assign mode_q       = st_q.mode;
    assign prev_valid_q = st_q.prev_valid;

    AST_MODE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !clear |=> $stable(mode_q)); // R6

endmodule

// File: rtl/tin_increment.sv
module tin_increment
    import trap_integ_pkg::*;
#(
    parameter int SAMPLE_W = 16,
    parameter int INC_W    = SAMPLE_W + 1
) (
    input  integ_mode_e               eff_mode,
    input  logic                      eff_first,
    input  logic        [SAMPLE_W-1:0] sample,
    input  logic        [SAMPLE_W-1:0] prev_sample,
    output logic signed [INC_W-1:0]   inc
);

    logic signed [INC_W-1:0] cur_x;
    logic signed [INC_W-1:0] prev_x;

    always_comb begin
        cur_x  = INC_W'($signed(sample));
        prev_x = INC_W'($signed(prev_sample));
        // increments are in half units: the mean (p+s)/2 becomes p+s
        if (eff_mode == MODE_RECT) begin
            inc = cur_x <<< 1;
        end else if (eff_first) begin
            inc = '0;
        end else begin
            inc = prev_x + cur_x;
        end
    end

endmodule

// File: rtl/tin_sat_accum.sv
module tin_sat_accum #(
    parameter int ACC_W = 28,
    parameter int INC_W = 17
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    clear,
    input  logic                    in_valid,
    input  logic signed [INC_W-1:0] inc,
    output logic        [ACC_W-1:0] acc,
    output logic                    out_valid,
    output logic                    ovf
);

    localparam logic [ACC_W-1:0] ACC_MAX = {1'b0, {(ACC_W-1){1'b1}}};
    localparam logic [ACC_W-1:0] ACC_MIN = {1'b1, {(ACC_W-1){1'b0}}};

    typedef struct packed {
        logic [ACC_W-1:0] acc;
        logic             vld;
        logic             ovf;
    } acc_t;

    acc_t st_d, st_q;
    logic [ACC_W-1:0] base_w;
    logic [ACC_W:0]   sum_w;

    always_comb begin
        st_d     = st_q;
        base_w   = clear ? '0 : st_q.acc;
        st_d.acc = base_w;
        st_d.ovf = clear ? 1'b0 : st_q.ovf;
        st_d.vld = in_valid;
        sum_w    = {base_w[ACC_W-1], base_w}
                 + {{(ACC_W+1-INC_W){inc[INC_W-1]}}, inc};
        if (in_valid) begin
            if (sum_w[ACC_W] != sum_w[ACC_W-1]) begin
                st_d.acc = sum_w[ACC_W] ? ACC_MIN : ACC_MAX;
                st_d.ovf = 1'b1;
            end else begin
                st_d.acc = sum_w[ACC_W-1:0];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '{acc: '0, vld: 1'b0, ovf: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign acc       = st_q.acc;
    assign out_valid = st_q.vld;
    assign ovf       = st_q.ovf;

    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
        ovf && !clear |=> ovf); // R8
    AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (rst)
        clear && !in_valid |=> acc == '0 && !ovf); // R5
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !clear && !in_valid |=> $stable(acc) && !out_valid); // R7

endmodule

// File: rtl/trap_integrator.sv
module trap_integrator
    import trap_integ_pkg::*;
#(
    parameter int SAMPLE_W   = 16,
    parameter int MAX_WINDOW = 1024,
    localparam int LOG_W     = $clog2(MAX_WINDOW),
    localparam int ACC_W     = SAMPLE_W + LOG_W + 2,
    localparam int INC_W     = SAMPLE_W + 1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                clear,
    input  logic                in_valid,
    input  logic [SAMPLE_W-1:0] in_sample,
    input  logic                mode_sel,
    output logic [ACC_W-1:0]    integral,
    output logic                out_valid,
    output logic                overflow
);

    integ_mode_e             eff_mode;
    integ_mode_e             mode_q;
    logic                    eff_first;
    logic                    prev_valid_q;
    logic [SAMPLE_W-1:0]     prev_sample;
    logic signed [INC_W-1:0] inc;

    tin_window_ctl #(.SAMPLE_W(SAMPLE_W)) u_wctl (
        .clk          (clk),
        .rst          (rst),
        .clear        (clear),
        .in_valid     (in_valid),
        .sample       (in_sample),
        .mode_in      (integ_mode_e'(mode_sel)),
        .eff_mode     (eff_mode),
        .eff_first    (eff_first),
        .prev_sample  (prev_sample),
        .mode_q       (mode_q),
        .prev_valid_q (prev_valid_q)
    );

    tin_increment #(.SAMPLE_W(SAMPLE_W), .INC_W(INC_W)) u_inc (
        .eff_mode    (eff_mode),
        .eff_first   (eff_first),
        .sample      (in_sample),
        .prev_sample (prev_sample),
        .inc         (inc)
    );

    tin_sat_accum #(.ACC_W(ACC_W), .INC_W(INC_W)) u_acc (
        .clk       (clk),
        .rst       (rst),
        .clear     (clear),
        .in_valid  (in_valid),
        .inc       (inc),
        .acc       (integral),
        .out_valid (out_valid),
        .ovf       (overflow)
    );

    AST_FIRST_NO_AREA: assert property (@(posedge clk) disable iff (rst)
        in_valid && !clear && mode_q == MODE_TRAP && !prev_valid_q
        |=> $stable(integral)); // R4
    AST_FIRST_AT_CLEAR: assert property (@(posedge clk) disable iff (rst)
        in_valid && clear && mode_sel |=> integral == '0); // R4
    AST_VALID_PULSE: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid); // R7

endmodule

// File: tb/sim_trap_integrator.sv
module sim_trap_integrator;

    localparam int CLK_PERIOD = 10;
    localparam int SW = 16;
    localparam int MW = 1024;
    localparam int AW = SW + $clog2(MW) + 2;
    localparam longint AMAX = (64'sd1 <<< (AW-1)) - 1;
    localparam longint AMIN = -(64'sd1 <<< (AW-1));

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic clear = 1'b0;
    logic in_valid = 1'b0;
    logic [SW-1:0] in_sample = '0;
    logic mode_sel = 1'b0;
    logic [AW-1:0] integral;
    logic out_valid;
    logic overflow;

    int checks = 0;
    int failures = 0;

    longint exp_q[$];
    bit     eovf_q[$];
    string  tag_q[$];

    longint m_acc = 0;
    longint m_prev = 0;
    bit     m_pv = 0;
    bit     m_mode = 0;
    bit     m_ovf = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    trap_integrator #(.SAMPLE_W(SW), .MAX_WINDOW(MW)) u0 (
        .clk(clk), .rst(rst), .clear(clear), .in_valid(in_valid),
        .in_sample(in_sample), .mode_sel(mode_sel),
        .integral(integral), .out_valid(out_valid), .overflow(overflow)
    );

    task automatic check(input string tag, input longint act, input longint expv);
        checks++;
        if (act != expv) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    function automatic longint integ_now();
        return longint'($signed(integral));
    endfunction

    task automatic send(input bit v, input bit clr, input bit md, input int s, input string tag);
        longint inc;
        @(negedge clk);
        in_valid  = v;
        clear     = clr;
        mode_sel  = md;
        in_sample = SW'(s);
        if (clr) begin
            m_acc = 0; m_pv = 0; m_ovf = 0; m_mode = md;
        end
        if (v) begin
            if (!m_mode) inc = 2 * longint'(s);
            else if (!m_pv) inc = 0;
            else inc = m_prev + longint'(s);
            m_acc = m_acc + inc;
            if (m_acc > AMAX) begin m_acc = AMAX; m_ovf = 1; end
            if (m_acc < AMIN) begin m_acc = AMIN; m_ovf = 1; end
            m_prev = s;
            m_pv   = 1;
            exp_q.push_back(m_acc);
            eovf_q.push_back(m_ovf);
            tag_q.push_back(tag);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
            clear    = 1'b0;
        end
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    endtask

    // monitor: compares each result a quarter period after the edge that made it
    always @(posedge clk) begin
        #(CLK_PERIOD/4);
        if (!rst && out_valid) begin
            if (exp_q.size() == 0) begin
                checks++; failures++;
                $display("FAIL R7 actual=out_valid expected=no result pending");
            end else begin
                longint e; bit eo; string t;
                e = exp_q.pop_front(); eo = eovf_q.pop_front(); t = tag_q.pop_front();
                check(t, integ_now(), e);
                check({t, " overflow"}, longint'(overflow), longint'(eo));
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 200000);
        failures++;
        $display("FAIL watchdog actual=running expected=finished");
        summary();
        $finish;
    end

    initial begin
        longint snap, trap_res, rect_res;
        int f[9];
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        check("R1 integral", integ_now(), 0);
        check("R1 out_valid", longint'(out_valid), 0);
        check("R1 overflow", longint'(overflow), 0);
        // R1 default rectangle mode with no clear; R2 accumulation
        send(1, 0, 1, 5, "R1");
        send(1, 0, 1, -3, "R2");
        idle(2);
        // R7 hold and single pulse
        snap = integ_now();
        check("R7 out_valid low", longint'(out_valid), 0);
        idle(3);
        check("R7 hold", integ_now(), snap);

        // R5 clear alone
        send(0, 1, 0, 0, "R5");
        idle(1);
        check("R5 cleared", integ_now(), 0);

        // R2 rectangle window opened with a sample (R5)
        send(1, 1, 0, 3, "R5");
        send(1, 0, 0, -7, "R2");
        send(1, 0, 0, 100, "R2");
        idle(2);

        // R3 R4 trapezoid, first sample together with clear
        send(1, 1, 1, 4, "R4");
        send(1, 0, 1, 6, "R3");
        send(1, 0, 1, -3, "R3");
        send(1, 0, 0, 9, "R6");  // mode change mid-window ignored
        send(1, 0, 0, -20, "R6");
        idle(2);

        // R4 window opened by clear alone, then first sample
        send(0, 1, 1, 0, "R5");
        send(1, 0, 1, 77, "R4");
        send(1, 0, 1, 1, "R3");
        idle(2);

        // R6 rectangle window, mode_sel toggles without clear
        send(1, 1, 0, 10, "R6");
        send(1, 0, 1, 11, "R6");
        send(1, 0, 1, 12, "R6");
        idle(2);

        // R8 positive saturation
        send(0, 1, 0, 0, "R5");
        for (int i = 0; i < 2060; i++) send(1, 0, 0, 32767, "R8");
        idle(2);
        check("R8 pos clamp", integ_now(), AMAX);
        check("R8 flag", longint'(overflow), 1);
        idle(2);
        check("R8 sticky", longint'(overflow), 1);
        // R5 clear with sample drops overflow
        send(1, 1, 0, 2, "R5");
        idle(2);
        check("R5 ovf cleared", longint'(overflow), 0);

        // R8 negative saturation in trapezoid mode
        send(1, 1, 1, -32768, "R8");
        for (int i = 0; i < 2060; i++) send(1, 0, 1, -32768, "R8");
        idle(2);
        check("R8 neg clamp", integ_now(), AMIN);
        check("R8 neg flag", longint'(overflow), 1);

        // R9 endpoint relation
        f = '{13, -40, 7, 250, -3, 99, 0, -17, 61};
        send(0, 1, 1, 0, "R9");
        for (int i = 0; i < 9; i++) send(1, 0, 1, f[i], "R9");
        idle(2);
        trap_res = integ_now();
        send(0, 1, 0, 0, "R9");
        for (int i = 1; i < 9; i++) send(1, 0, 0, f[i], "R9");
        idle(2);
        rect_res = integ_now();
        check("R9 endpoint difference", rect_res - trap_res, longint'(f[8] - f[0]));

        idle(2);
        check("R7 all results seen", longint'(exp_q.size()), 0);
        summary();
        $finish;
    end

endmodule